// File: doc/BRIEF.md
# Clock Output Gating and Power-Down Sequencer

This block is the digital control core of a multi-output clock generator. From one core clock it divides six clock groups: a host clock, a memory-reference clock with an inverted companion, a 66 MHz-class clock, a PCI-class clock, a 48 MHz clock and a reference clock. A mode code sets the ratios between the groups. The block can also float every output, or derive the outputs from a test clock that arrives as a one-cycle tick input. The oscillator, the PLL, the analog spreading and the output pads sit outside the block. The block models them only as the enable lines it drives and the strap pins it reads.

Power-down is requested through an asynchronous active-low pin. After the request is synchronized, the block closes every output gate at that output's own falling edge. It removes the VCO enable only when all outputs are parked low, and it removes the crystal enable after that. Power-up runs the same steps in reverse. The crystal starts first. The VCO starts after a programmable settling count, and the outputs are released after a second count of the same length. Two multiplier straps are captured once after reset. The pins they share are then handed to the reference output.

Top module: `clkgen_ctrl`

## Requirements
- R1: The power-down pin passes through a two-flop synchronizer clocked by `clk`. A low pulse that covers no rising edge of `clk` has no effect: the VCO enable stays high and the outputs keep toggling.
- R2: When power-down is taken, each output ends its current high phase in full and then stays low until the next power-up. Once the sequence reaches the off state, all seven clock outputs are low.
- R3: `vco_en` falls only after every output gate is closed. No clock output is high while `vco_en` is low.
- R4: `xtal_en` falls only after `vco_en` is low. On power-up, `xtal_en` is high for exactly `PU_WAIT` cycles before `vco_en` rises, and the outputs start at least `PU_WAIT` cycles after `vco_en` rises. With a 14.318 MHz core clock, `PU_WAIT` must stay below 21,477 so that the whole power-up is shorter than 3 ms.
- R5: While both of its gates are open, `mref_clk_b` is the logical inverse of `mref_clk`.
- R6: `mult_sel` captures `strap_pins` on the first clock after reset and never changes afterwards. `ref_drv_en` goes high once the capture is done.
- R7: `spread_n` is active low. It is registered once. While it is low, `spread_grp` is 6'b001111, where bit 0 is host, 1 is memory reference, 2 is 66 MHz, 3 is PCI, 4 is 48 MHz and 5 is reference. Bits 4 and 5 are always 0.
- R8: The mode code is {`sel_hi`, `fs[0]`, `fs[1]`}. Code 000 gives host/mref/66/pci periods of 4/8/6/12 core cycles. Code 100 gives 3/6/6/12. In both codes, 48 MHz and reference use `P_F48` and `P_REF` (10 and 14 by default).
- R9: Code 010 drives `clk_oe` low. Every other legal mode holds `clk_oe` high.
- R10: Code 111 is test mode. The dividers advance only on `test_tick`, one tick per test-clock edge. Host runs at test/2 (period 4 ticks), memory reference at test/4 (8 ticks) and 66 MHz at the test rate (2 ticks).
- R11: Codes 001, 011, 101 and 110 are reserved. They raise `bad_code` and leave the previous mode and its output periods in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; all logic runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req_n | input | 1 | Asynchronous active-low power-down request |
| sel_hi | input | 1 | Host rate select; forms the high bit of the mode code |
| fs | input | 2 | Frequency select; fs[0] is the middle code bit, fs[1] the low bit |
| spread_n | input | 1 | Active-low spread-spectrum request |
| test_tick | input | 1 | One pulse per test-clock edge; used in test mode |
| strap_pins | input | 2 | Multiplier straps sampled after reset |
| host_clk | output | 1 | Gated host clock |
| mref_clk | output | 1 | Gated memory-reference clock |
| mref_clk_b | output | 1 | Gated inverted memory-reference clock |
| clk66 | output | 1 | Gated 66 MHz-class clock |
| pci_clk | output | 1 | Gated PCI-class clock |
| clk48 | output | 1 | Gated 48 MHz clock |
| ref_clk | output | 1 | Gated reference clock |
| clk_oe | output | 1 | Output-stage enable; low in the float mode |
| spread_grp | output | 6 | Per-group spread enable |
| mult_sel | output | 2 | Captured multiplier straps |
| ref_drv_en | output | 1 | Shared strap/reference pins now driven as outputs |
| bad_code | output | 1 | Current mode code is reserved |
| xtal_en | output | 1 | Crystal oscillator enable |
| vco_en | output | 1 | VCO enable |

## Verification
The assertions check the following on every cycle. No output falls unless its divider falls, so a gate never cuts a high phase short. The VCO and crystal enables rise and fall in the required order. The memory-reference pair stays complementary. The straps stay frozen once captured. A reserved code never moves the mode. Only the bench scenarios can show the values behind these rules: the measured period of each group in each mode, the exact settling counts during power-up, the rejection of a sub-cycle power-down glitch, and the float and spread outputs after a code change.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  typedef enum logic [1:0] {M_RUN100, M_RUN133, M_TRI, M_TEST} mode_e;
  typedef enum logic [2:0] {S_DOWN, S_XTAL, S_VCO, S_RUN, S_STOP, S_VCOFF} pstate_e;

  localparam int NGRP = 6;         // divided groups: host, mref, 66, pci, 48, ref
  localparam int NOUT = NGRP + 1;  // plus inverted memory reference
  localparam int G_HOST = 0;
  localparam int G_MREF = 1;
  localparam int G_66   = 2;
  localparam int G_PCI  = 3;
  localparam int G_48   = 4;
  localparam int G_REF  = 5;
  localparam int G_MREFB = 6;

  // code = {sel_hi, fs[0], fs[1]}
  function automatic logic code_legal(input logic [2:0] code);
    return (code == 3'b000) || (code == 3'b100) || (code == 3'b010) || (code == 3'b111);
  endfunction

  function automatic mode_e code_mode(input logic [2:0] code);
    case (code)
      3'b100:  return M_RUN133;
      3'b010:  return M_TRI;
      3'b111:  return M_TEST;
      default: return M_RUN100;
    endcase
  endfunction
endpackage

// File: rtl/pd_sync.sv
module pd_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/grp_div.sv
module grp_div #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          adv,
  input  logic [PW-1:0] per,
  output logic          raw
);
  logic [PW-1:0] cnt;
  logic [PW-1:0] nxt;
  logic [PW-1:0] half;

  assign half = {1'b0, per[PW-1:1]};

  always_comb begin
    if (cnt >= per - PW'(1)) nxt = '0;
    else                     nxt = cnt + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      raw <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      raw <= 1'b0;
    end else if (adv) begin
      cnt <= nxt;
      raw <= (nxt < half);
    end
  end
endmodule

// File: rtl/out_gate.sv
module out_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic want,
  output logic gate,
  output logic clk_o
);
  // enable may only move while the divided clock is low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   gate <= 1'b0;
    else if (!raw) gate <= want;
  end

  assign clk_o = raw & gate;

  AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_o) |-> $fell(raw)); // R2
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
  import clkgen_pkg::*;
#(
  parameter int WAIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_ok,
  input  logic start_ok,
  input  logic all_closed,
  output logic xtal_en,
  output logic vco_en,
  output logic run_req
);
  localparam int CW = $clog2(WAIT + 1);

  pstate_e       st;
  logic [CW-1:0] cnt;
  logic          cnt_done;

  assign cnt_done = (cnt == CW'(WAIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_DOWN;
      cnt <= '0;
    end else begin
      case (st)
        S_DOWN: if (pd_ok && start_ok) begin
          st  <= S_XTAL;
          cnt <= '0;
        end
        S_XTAL: begin
          if (!pd_ok)        st <= S_DOWN;
          else if (cnt_done) begin
            st  <= S_VCO;
            cnt <= '0;
          end else           cnt <= cnt + CW'(1);
        end
        S_VCO: begin
          if (!pd_ok)        st <= S_STOP;
          else if (cnt_done) st <= S_RUN;
          else               cnt <= cnt + CW'(1);
        end
        S_RUN:   if (!pd_ok) st <= S_STOP;
        S_STOP:  if (all_closed) st <= S_VCOFF;
        S_VCOFF: st <= S_DOWN;
        default: st <= S_DOWN;
      endcase
    end
  end

  assign xtal_en = (st != S_DOWN);
  assign vco_en  = (st == S_VCO) || (st == S_RUN) || (st == S_STOP);
  assign run_req = (st == S_RUN);

  AST_VCO_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vco_en) |-> $past(all_closed)); // R3
  AST_XTAL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xtal_en) |-> (!vco_en && !$past(vco_en))); // R4
  AST_PU_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vco_en) |-> (xtal_en && $past(xtal_en))); // R4
  AST_RUN_NEEDS_VCO: assert property (@(posedge clk) disable iff (!rst_n)
    run_req |-> (vco_en && xtal_en)); // R4
endmodule

// File: rtl/clkgen_ctrl.sv
module clkgen_ctrl
  import clkgen_pkg::*;
#(
  parameter int PW        = 8,
  parameter int P_HOST100 = 4,
  parameter int P_HOST133 = 3,
  parameter int P_66      = 6,
  parameter int P_F48     = 10,
  parameter int P_REF     = 14,
  parameter int PU_WAIT   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pd_req_n,
  input  logic       sel_hi,
  input  logic [1:0] fs,
  input  logic       spread_n,
  input  logic       test_tick,
  input  logic [1:0] strap_pins,
  output logic       host_clk,
  output logic       mref_clk,
  output logic       mref_clk_b,
  output logic       clk66,
  output logic       pci_clk,
  output logic       clk48,
  output logic       ref_clk,
  output logic       clk_oe,
  output logic [5:0] spread_grp,
  output logic [1:0] mult_sel,
  output logic       ref_drv_en,
  output logic       bad_code,
  output logic       xtal_en,
  output logic       vco_en
);
  localparam int P_MREF100 = 2 * P_HOST100;  // half the host rate
  localparam int P_MREF133 = P_66;           // about 66 MHz
  localparam int P_PCI     = 2 * P_66;       // half the 66 MHz rate
  localparam int T_HOST    = 4;              // test/2 in ticks
  localparam int T_MREF    = 8;              // test/4
  localparam int T_BASE    = 2;              // test rate
  localparam int T_PCI     = 12;             // test/6

  logic          pd_ok;
  logic [2:0]    sel_q;
  logic          spread_q;
  mode_e         mode_q;
  logic          strap_done;
  logic [1:0]    mult_q;
  logic          run_req;
  logic          all_closed;
  logic          adv;
  logic [PW-1:0] per_v [NGRP];
  logic [NOUT-1:0] raw_v;
  logic [NOUT-1:0] gate_v;
  logic [NOUT-1:0] out_v;

  pd_sync #(.STAGES(2), .RST_VAL(1'b0)) u_pd (
    .clk(clk), .rst_n(rst_n), .d(pd_req_n), .q(pd_ok));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= 3'b000;
      spread_q <= 1'b1;
      mode_q   <= M_RUN100;
    end else begin
      sel_q    <= {sel_hi, fs[0], fs[1]};
      spread_q <= spread_n;
      if (code_legal(sel_q)) mode_q <= code_mode(sel_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_done <= 1'b0;
      mult_q     <= 2'b00;
    end else if (!strap_done) begin
      strap_done <= 1'b1;
      mult_q     <= strap_pins;
    end
  end

  always_comb begin
    per_v[G_48]  = PW'(P_F48);
    per_v[G_REF] = PW'(P_REF);
    per_v[G_66]  = PW'(P_66);
    per_v[G_PCI] = PW'(P_PCI);
    case (mode_q)
      M_RUN133: begin
        per_v[G_HOST] = PW'(P_HOST133);
        per_v[G_MREF] = PW'(P_MREF133);
      end
      M_TEST: begin
        per_v[G_HOST] = PW'(T_HOST);
        per_v[G_MREF] = PW'(T_MREF);
        per_v[G_66]   = PW'(T_BASE);
        per_v[G_PCI]  = PW'(T_PCI);
        per_v[G_48]   = PW'(T_BASE);
        per_v[G_REF]  = PW'(T_BASE);
      end
      default: begin
        per_v[G_HOST] = PW'(P_HOST100);
        per_v[G_MREF] = PW'(P_MREF100);
      end
    endcase
  end

  assign adv = (mode_q == M_TEST) ? test_tick : 1'b1;

  for (genvar g = 0; g < NGRP; g++) begin : g_div
    if (g == G_REF) begin : g_xtal_dom
      grp_div #(.PW(PW)) u_div (
        .clk(clk), .rst_n(rst_n), .run(xtal_en), .adv(adv),
        .per(per_v[g]), .raw(raw_v[g]));
    end else begin : g_vco_dom
      grp_div #(.PW(PW)) u_div (
        .clk(clk), .rst_n(rst_n), .run(vco_en), .adv(adv),
        .per(per_v[g]), .raw(raw_v[g]));
    end
  end

  assign raw_v[G_MREFB] = ~raw_v[G_MREF];

  for (genvar o = 0; o < NOUT; o++) begin : g_gate
    out_gate u_gate (
      .clk(clk), .rst_n(rst_n), .raw(raw_v[o]), .want(run_req),
      .gate(gate_v[o]), .clk_o(out_v[o]));
  end

  assign all_closed = ~|gate_v;

  pwr_seq #(.WAIT(PU_WAIT)) u_seq (
    .clk(clk), .rst_n(rst_n), .pd_ok(pd_ok), .start_ok(strap_done),
    .all_closed(all_closed), .xtal_en(xtal_en), .vco_en(vco_en),
    .run_req(run_req));

  assign host_clk   = out_v[G_HOST];
  assign mref_clk   = out_v[G_MREF];
  assign mref_clk_b = out_v[G_MREFB];
  assign clk66      = out_v[G_66];
  assign pci_clk    = out_v[G_PCI];
  assign clk48      = out_v[G_48];
  assign ref_clk    = out_v[G_REF];
  assign clk_oe     = (mode_q != M_TRI);
  assign spread_grp = {2'b00, {4{~spread_q}}};
  assign mult_sel   = mult_q;
  assign ref_drv_en = strap_done;
  assign bad_code   = ~code_legal(sel_q);

  AST_MREF_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_v[G_MREF] && gate_v[G_MREFB]) |-> (mref_clk != mref_clk_b)); // R5
  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strap_done) |-> $stable(mult_sel)); // R6
  AST_SPREAD_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (spread_grp[0] == !$past(spread_n))); // R7
  AST_RSV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bad_code) |-> $stable(mode_q)); // R11
  AST_DARK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !vco_en |-> (out_v == '0)); // R3
endmodule

// File: tb/sim_clkgen_ctrl.sv
module sim_clkgen_ctrl;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_req_n = 1'b1;
  logic sel_hi = 1'b0;
  logic [1:0] fs = 2'b00;
  logic spread_n = 1'b1;
  logic test_tick = 1'b1;
  logic [1:0] strap_pins = 2'b10;
  logic host_clk, mref_clk, mref_clk_b, clk66, pci_clk, clk48, ref_clk;
  logic clk_oe, ref_drv_en, bad_code, xtal_en, vco_en;
  logic [5:0] spread_grp;
  logic [1:0] mult_sel;

  int checks = 0;
  int fails = 0;
  int order_viol = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  clkgen_ctrl #(.PU_WAIT(W)) u0 (
    .clk(clk), .rst_n(rst_n), .pd_req_n(pd_req_n), .sel_hi(sel_hi), .fs(fs),
    .spread_n(spread_n), .test_tick(test_tick), .strap_pins(strap_pins),
    .host_clk(host_clk), .mref_clk(mref_clk), .mref_clk_b(mref_clk_b),
    .clk66(clk66), .pci_clk(pci_clk), .clk48(clk48), .ref_clk(ref_clk),
    .clk_oe(clk_oe), .spread_grp(spread_grp), .mult_sel(mult_sel),
    .ref_drv_en(ref_drv_en), .bad_code(bad_code), .xtal_en(xtal_en),
    .vco_en(vco_en));

  wire [6:0] clks = {mref_clk_b, ref_clk, clk48, pci_clk, clk66, mref_clk, host_clk};

  // ordering monitor for R3 / R4
  always @(negedge clk) begin
    if (rst_n) begin
      if (!vco_en && (clks != 7'd0)) order_viol++;
      if (!xtal_en && vco_en) order_viol++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic meas(input int idx, output int per);
    bit prev, cur, seen;
    int n;
    per = -1;
    seen = 1'b0;
    n = 0;
    @(negedge clk);
    prev = clks[idx];
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      cur = clks[idx];
      if (seen) n++;
      if (!prev && cur) begin
        if (seen) begin
          per = n;
          break;
        end
        seen = 1'b1;
        n = 0;
      end
      prev = cur;
    end
  endtask

  task automatic set_code(input logic [2:0] code);
    @(negedge clk);
    sel_hi = code[2];
    fs[0]  = code[1];
    fs[1]  = code[0];
    repeat (12) @(negedge clk);
  endtask

  task automatic count_powerup(input string req);
    int xonly = 0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (xtal_en && !vco_en) xonly++;
      if (vco_en) break;
    end
    chk(xonly == W, req, xonly, W);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(clks == 7'd0, "R2", clks, 0);
    chk(!xtal_en && !vco_en, "R4", {xtal_en, vco_en}, 0);
    chk(!ref_drv_en, "R6", ref_drv_en, 0);
  endtask

  task automatic t_startup;
    int lag = 0;
    @(negedge clk);
    rst_n = 1'b1;
    count_powerup("R4");
    for (int i = 0; i < 200; i++) begin
      if (host_clk) break;
      lag++;
      @(negedge clk);
    end
    chk(lag >= W, "R4", lag, W);
    chk(mult_sel == 2'b10, "R6", mult_sel, 2);
    chk(ref_drv_en, "R6", ref_drv_en, 1);
    strap_pins = 2'b01;
    repeat (8) @(negedge clk);
    chk(mult_sel == 2'b10, "R6", mult_sel, 2);
  endtask

  task automatic t_run100;
    int p;
    int bad = 0;
    meas(0, p); chk(p == 4,  "R8", p, 4);
    meas(1, p); chk(p == 8,  "R8", p, 8);
    meas(2, p); chk(p == 6,  "R8", p, 6);
    meas(3, p); chk(p == 12, "R8", p, 12);
    meas(4, p); chk(p == 10, "R8", p, 10);
    meas(5, p); chk(p == 14, "R8", p, 14);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (mref_clk == mref_clk_b) bad++;
    end
    chk(bad == 0, "R5", bad, 0);
    chk(clk_oe && !bad_code, "R9", clk_oe, 1);
  endtask

  task automatic t_run133;
    int p;
    set_code(3'b100);
    meas(0, p); chk(p == 3,  "R8", p, 3);
    meas(1, p); chk(p == 6,  "R8", p, 6);
    meas(3, p); chk(p == 12, "R8", p, 12);
  endtask

  task automatic t_reserved;
    int p;
    set_code(3'b101);
    chk(bad_code, "R11", bad_code, 1);
    meas(0, p); chk(p == 3, "R11", p, 3);
    set_code(3'b011);
    chk(bad_code, "R11", bad_code, 1);
    meas(1, p); chk(p == 6, "R11", p, 6);
    set_code(3'b000);
    chk(!bad_code, "R11", bad_code, 0);
  endtask

  task automatic t_tristate;
    set_code(3'b010);
    chk(!clk_oe, "R9", clk_oe, 0);
    set_code(3'b000);
    chk(clk_oe, "R9", clk_oe, 1);
  endtask

  task automatic t_spread;
    @(negedge clk); spread_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(spread_grp == 6'b001111, "R7", spread_grp, 15);
    spread_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(spread_grp == 6'b000000, "R7", spread_grp, 0);
  endtask

  task automatic t_testmode;
    int p;
    set_code(3'b111);
    meas(0, p); chk(p == 4, "R10", p, 4);
    meas(1, p); chk(p == 8, "R10", p, 8);
    meas(2, p); chk(p == 2, "R10", p, 2);
    set_code(3'b000);
  endtask

  task automatic t_glitch;
    int p;
    @(posedge clk);
    #3 pd_req_n = 1'b0;
    #4 pd_req_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(vco_en, "R1", vco_en, 1);
    meas(0, p); chk(p == 4, "R1", p, 4);
  endtask

  task automatic t_powerdown;
    int p;
    int lit = 0;
    order_viol = 0;
    @(negedge clk); pd_req_n = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!xtal_en) break;
    end
    chk(!xtal_en && !vco_en, "R4", {xtal_en, vco_en}, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (clks != 7'd0) lit++;
    end
    chk(lit == 0, "R2", lit, 0);
    chk(order_viol == 0, "R3", order_viol, 0);
    @(negedge clk); pd_req_n = 1'b1;
    count_powerup("R4");
    meas(0, p); chk(p == 4, "R4", p, 4);
    chk(order_viol == 0, "R3", order_viol, 0);
  endtask

  initial begin
    t_reset();
    t_startup();
    t_run100();
    t_run133();
    t_reserved();
    t_tristate();
    t_spread();
    t_testmode();
    t_glitch();
    t_powerdown();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule